// File: doc/BRIEF.md
# Three-Generator Configurable Logic Tile

The tile is one programmable logic cell of an FPGA-style fabric. Two lookup-table generators, F and G, each evaluate any function of their own four input pins. A third, smaller generator H takes the F result, the G result and one extra direct pin, so a single configuration of the tile can realise one function of up to nine independent inputs. Two output paths, X and Y, each pick either their own 4-input generator or H. Each path has a flip-flop with a synchronous reset and a clock enable. Each path's main output can be set to show either the flip-flop or the combinational value. The flip-flop outputs are also always available on their own pins.

The F and G truth-table storage can also be switched into a writable memory. It can be organised as 16 words of 2 bits or as 32 words of 1 bit, with edge-triggered writes. A dedicated carry path through F and G turns the tile into a 2-bit adder slice, and slices chain through carry-in and carry-out. All tables and mode bits are loaded through a serial shift port.

Top module: `lut_tile`

## Requirements
- R1: F output is bit `f_in` of the F table and G output is bit `g_in` of the G table, where the table bit index equals the 4-bit input value.
- R2: H output is bit `{h_in, G, F}` of the 8-bit H table (h_in is the index MSB, F the LSB). A path set to take H therefore realises a 9-input function.
- R3: Mode bit 3 selects the X source (0 = F, 1 = H) and mode bit 4 selects the Y source (0 = G, 1 = H).
- R4: `xq`/`yq` capture their path source one clock edge after it is presented while `ce` is high. With mode bit 5 (X) or bit 6 (Y) set, `x_o`/`y_o` equal the flip-flop; otherwise they are combinational.
- R5: With `rst_n` low at an edge, `xq` and `yq` become 0. With `ce` low, they hold their value.
- R6: While `cfg_en` is high, each edge shifts `cfg_din` into a 47-bit chain. After 47 edges the first bit shifted in sits in F table bit 0. The layout, from first bit to last, is F bits 0..15, G bits 0..15, H bits 0..7, then mode bits 0..6 (bit 0 memory enable, bit 1 32x1 organisation, bit 2 carry enable, bits 3..6 as in R3/R4).
- R7: While `cfg_en` is high, `x_o`, `y_o` and `cout` are 0, and `xq`/`yq` are cleared at each edge.
- R8: In memory mode with 16x2 organisation, `f_in` addresses both tables. A write stores `wdata[0]` in F and `wdata[1]` in G. X (source F) and Y (source G) read F and G at `f_in`, and `g_in` is ignored.
- R9: In memory mode with 32x1 organisation, the address is `{h_in, f_in}` (h_in = 0 selects the F table). A write stores `wdata[0]`, and H acts as a 2:1 multiplexer, so a path taking H returns the addressed bit.
- R10: A memory write happens at an edge only when `we` and `ce` are both high. Before that edge, reads return the old contents.
- R11: With carry enabled (and memory mode off), the F carry input is `cin` and the G carry input is the F carry-out. Each replaces its generator's input bit 3. Each stage's carry-out is the majority of its pins 0 and 1 and its carry input. `cout` is the G carry-out.
- R12: With carry disabled, or with memory mode on, `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| f_in | input | LUT_IN | F generator pins / memory address |
| g_in | input | LUT_IN | G generator pins |
| h_in | input | 1 | Extra H input / memory address MSB |
| ce | input | 1 | Clock enable for flip-flops and writes |
| we | input | 1 | Memory write enable |
| wdata | input | 2 | Memory write data |
| cin | input | 1 | Carry input |
| cout | output | 1 | Carry output |
| x_o | output | 1 | X path output (registered or combinational) |
| y_o | output | 1 | Y path output (registered or combinational) |
| xq | output | 1 | X path flip-flop |
| yq | output | 1 | Y path flip-flop |

## Verification
Generator, H, carry and memory-read results are combinational, so they are due in the same cycle the pins change. The bench drives inputs at the falling edge and compares 1 ns later. Flip-flop results and memory writes take effect at the next rising edge. They are compared at the following falling edge, and the old memory word is also confirmed before that edge. A configuration takes effect only after 47 shift edges and the edge that lowers `cfg_en`, and every compare waits until that point.

// File: rtl/lut_tile_pkg.sv
// Shared constants and the mode-bit layout of the logic tile.
// Assumes the H generator always has three inputs (F, G, extra pin).
package lut_tile_pkg;
    localparam int H_IN   = 3;
    localparam int H_TAB  = 1 << H_IN;
    localparam int MODE_W = 7;

    // Field order fixes the serial bit order: ram_en is mode bit 0.
    typedef struct packed {
        logic y_reg;
        logic x_reg;
        logic y_src_h;
        logic x_src_h;
        logic carry_en;
        logic ram_wide;
        logic ram_en;
    } mode_t;
endpackage

// File: rtl/lut_tile_cfg.sv
// Configuration chain holding the F, G and H tables and the mode bits.
// Shifts serially under cfg_en; outside configuration, single-bit memory
// writes land in the F or G table slice. Assumes writes are pre-qualified.
module lut_tile_cfg
    import lut_tile_pkg::*;
#(
    parameter int LUT_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic              wr_f,
    input  logic              wr_g,
    input  logic [LUT_IN-1:0] wr_addr,
    input  logic              wr_bit_f,
    input  logic              wr_bit_g,
    output logic [(1<<LUT_IN)-1:0] f_tab,
    output logic [(1<<LUT_IN)-1:0] g_tab,
    output logic [H_TAB-1:0]  h_tab,
    output mode_t             mode
);
    localparam int TAB   = 1 << LUT_IN;
    localparam int CHAIN = 2 * TAB + H_TAB + MODE_W;

    logic [CHAIN-1:0] chain_q;

    // Shift configuration in at the top, or apply a memory write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (cfg_en) begin
            chain_q <= {cfg_din, chain_q[CHAIN-1:1]};
        end else begin
            if (wr_f) chain_q[int'(wr_addr)] <= wr_bit_f;
            if (wr_g) chain_q[TAB + int'(wr_addr)] <= wr_bit_g;
        end
    end

    assign f_tab = chain_q[TAB-1:0];
    assign g_tab = chain_q[2*TAB-1:TAB];
    assign h_tab = chain_q[2*TAB+H_TAB-1:2*TAB];
    assign mode  = mode_t'(chain_q[CHAIN-1:CHAIN-MODE_W]);
endmodule

// File: rtl/lut_fgen.sv
// One 4-input function generator with its dedicated carry stage.
// With carry_use set, the top index bit is replaced by the carry input.
// Assumes LUT_IN >= 3 so pins 0 and 1 are free for the carry operands.
module lut_fgen #(
    parameter int LUT_IN = 4
) (
    input  logic [(1<<LUT_IN)-1:0] tab,
    input  logic [LUT_IN-1:0]      pins,
    input  logic                   carry_use,
    input  logic                   cin,
    output logic                   o,
    output logic                   cout
);
    logic [LUT_IN-1:0] idx;

    // Form the table index, swapping in the carry when chaining.
    always_comb begin
        idx = pins;
        if (carry_use) idx[LUT_IN-1] = cin;
    end

    assign o    = tab[idx];
    assign cout = (pins[0] & pins[1]) | (cin & (pins[0] ^ pins[1]));
endmodule

// File: rtl/lut_hgen.sv
// Three-input H generator combining F, G and an extra pin.
// In wide-memory mode it becomes a plain 2:1 mux (extra pin selects G).
module lut_hgen
    import lut_tile_pkg::*;
(
    input  logic [H_TAB-1:0] tab,
    input  logic             f,
    input  logic             g,
    input  logic             x,
    input  logic             as_mux,
    output logic             o
);
    // Table lookup or fixed multiplexer.
    always_comb begin
        if (as_mux) o = x ? g : f;
        else        o = tab[{x, g, f}];
    end
endmodule

// File: rtl/lut_outreg.sv
// Two output paths, each with a flip-flop (sync reset, clock enable,
// cleared during configuration) and a registered/combinational select.
module lut_outreg #(
    parameter int PATHS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             ce,
    input  logic [PATHS-1:0] d,
    input  logic [PATHS-1:0] reg_sel,
    output logic [PATHS-1:0] q,
    output logic [PATHS-1:0] o
);
    for (genvar p = 0; p < PATHS; p++) begin : g_path
        // Path flip-flop.
        always_ff @(posedge clk) begin
            if (!rst_n || cfg_en) q[p] <= 1'b0;
            else if (ce)          q[p] <= d[p];
        end
        // Visible path output.
        assign o[p] = cfg_en ? 1'b0 : (reg_sel[p] ? q[p] : d[p]);
    end
endmodule

// File: rtl/lut_tile.sv
// Configurable logic tile: F and G generators, H combiner, carry path,
// distributed-memory mode and two output paths. Configuration enters
// serially; memory writes need we and ce and are ignored while cfg_en.
module lut_tile
    import lut_tile_pkg::*;
#(
    parameter int LUT_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [LUT_IN-1:0] f_in,
    input  logic [LUT_IN-1:0] g_in,
    input  logic              h_in,
    input  logic              ce,
    input  logic              we,
    input  logic [1:0]        wdata,
    input  logic              cin,
    output logic              cout,
    output logic              x_o,
    output logic              y_o,
    output logic              xq,
    output logic              yq
);
    localparam int TAB = 1 << LUT_IN;

    logic [TAB-1:0]    f_tab, g_tab;
    logic [H_TAB-1:0]  h_tab;
    mode_t             mode;
    logic              we_act, wr_f, wr_g, wr_bit_g;
    logic [LUT_IN-1:0] g_pins;
    logic              carry_use, f_out, g_out, h_out, f_cout, g_cout;
    logic [1:0]        path_d, path_q, path_o, path_sel;

    // Memory write qualification and table steering.
    assign we_act   = we & ce & mode.ram_en & ~cfg_en;
    assign wr_f     = we_act & (~mode.ram_wide | ~h_in);
    assign wr_g     = we_act & (~mode.ram_wide | h_in);
    assign wr_bit_g = mode.ram_wide ? wdata[0] : wdata[1];

    lut_tile_cfg #(.LUT_IN(LUT_IN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .wr_f(wr_f), .wr_g(wr_g), .wr_addr(f_in),
        .wr_bit_f(wdata[0]), .wr_bit_g(wr_bit_g),
        .f_tab(f_tab), .g_tab(g_tab), .h_tab(h_tab), .mode(mode)
    );

    // In memory mode both tables share the F address pins.
    assign g_pins    = mode.ram_en ? f_in : g_in;
    assign carry_use = mode.carry_en & ~mode.ram_en;

    lut_fgen #(.LUT_IN(LUT_IN)) u_fgen (
        .tab(f_tab), .pins(f_in), .carry_use(carry_use), .cin(cin),
        .o(f_out), .cout(f_cout)
    );

    lut_fgen #(.LUT_IN(LUT_IN)) u_ggen (
        .tab(g_tab), .pins(g_pins), .carry_use(carry_use), .cin(f_cout),
        .o(g_out), .cout(g_cout)
    );

    lut_hgen u_hgen (
        .tab(h_tab), .f(f_out), .g(g_out), .x(h_in),
        .as_mux(mode.ram_en & mode.ram_wide), .o(h_out)
    );

    assign cout = carry_use & ~cfg_en & g_cout;

    // Output path sources and register selects.
    assign path_d   = {mode.y_src_h ? h_out : g_out, mode.x_src_h ? h_out : f_out};
    assign path_sel = {mode.y_reg, mode.x_reg};

    lut_outreg #(.PATHS(2)) u_out (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ce(ce),
        .d(path_d), .reg_sel(path_sel), .q(path_q), .o(path_o)
    );

    assign x_o = path_o[0];
    assign y_o = path_o[1];
    assign xq  = path_q[0];
    assign yq  = path_q[1];
endmodule

// File: rtl/lut_tile_chk.sv
// Temporal checks on the logic tile, bound into every lut_tile instance.
module lut_tile_chk #(
    parameter int TAB = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_en,
    input logic           ce,
    input logic           we,
    input logic           cout,
    input logic           x_o,
    input logic           y_o,
    input logic           xq,
    input logic           yq,
    input logic           x_reg,
    input logic           y_reg,
    input logic [1:0]     path_d,
    input logic [TAB-1:0] f_tab,
    input logic [TAB-1:0] g_tab
);
    // R7
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (x_o == 1'b0 && y_o == 1'b0 && cout == 1'b0));

    // R5
    ff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !cfg_en) |=> ($stable(xq) && $stable(yq)));

    // R4
    ff_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !cfg_en) |=> (xq == $past(path_d[0]) && yq == $past(path_d[1])));

    // R4
    reg_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en) |-> ((!x_reg || x_o == xq) && (!y_reg || y_o == yq)));

    // R10
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !(we && ce)) |=> ($stable(f_tab) && $stable(g_tab)));
endmodule

bind lut_tile lut_tile_chk #(.TAB(TAB)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ce(ce), .we(we),
    .cout(cout), .x_o(x_o), .y_o(y_o), .xq(xq), .yq(yq),
    .x_reg(mode.x_reg), .y_reg(mode.y_reg), .path_d(path_d),
    .f_tab(f_tab), .g_tab(g_tab)
);

// File: tb/lut_tile_bench.sv
module lut_tile_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] f_in = '0, g_in = '0, f_hi = '0, g_hi = '0;
    logic h_in = 1'b0, ce = 1'b0, we = 1'b0, cin = 1'b0;
    logic [1:0] wdata = '0;
    logic cout, x_o, y_o, xq, yq;
    logic cout_hi, x_hi, y_hi, xq_hi, yq_hi;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lut_tile u_lut_tile (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .f_in(f_in), .g_in(g_in), .h_in(h_in), .ce(ce), .we(we),
        .wdata(wdata), .cin(cin), .cout(cout), .x_o(x_o), .y_o(y_o),
        .xq(xq), .yq(yq)
    );

    lut_tile u_lut_tile_hi (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .f_in(f_hi), .g_in(g_hi), .h_in(h_in), .ce(ce), .we(we),
        .wdata(wdata), .cin(cout), .cout(cout_hi), .x_o(x_hi), .y_o(y_hi),
        .xq(xq_hi), .yq(yq_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // mode bit 0 mem, 1 wide, 2 carry, 3 x<-H, 4 y<-H, 5 x reg, 6 y reg
    function automatic logic [6:0] mk_mode(bit mem, bit wide, bit cy, bit xh, bit yh, bit xr, bit yr);
        return {yr, xr, yh, xh, cy, wide, mem};
    endfunction

    // R6: serial load, first bit = F bit 0; R7 checked mid-load
    task automatic load(input logic [15:0] ft, input logic [15:0] gt,
                        input logic [7:0] ht, input logic [6:0] md);
        logic [46:0] v;
        v = {md, ht, gt, ft};
        for (int i = 0; i < 47; i++) begin
            @(negedge clk);
            cfg_din = v[i];
            cfg_en  = 1'b1;
            if (i == 6) begin
                #1;
                chk("R7 x_o during config", x_o, 0);
                chk("R7 y_o during config", y_o, 0);
                chk("R7 xq during config", xq, 0);
                chk("R7 cout during config", cout, 0);
            end
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    initial begin
        logic [15:0] ft, gt, mf, mg;
        logic [7:0]  ht;
        logic [31:0] m32;
        logic exp_x, exp_y, fo, go, oldx;
        void'($urandom(32'd2024));

        // R5 reset state
        ce = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R5 xq at reset", xq, 0);
        chk("R5 yq at reset", yq, 0);
        chk("R1 x_o empty table", x_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        ce = 1'b0;

        // R1 R2 R3: random tables, every 9-input combination, both routings
        for (int t = 0; t < 6; t++) begin
            ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
            if (t == 0) begin ft = 16'h8000; gt = 16'h0001; end
            load(ft, gt, ht, (t % 2 == 0) ? mk_mode(0,0,0,1,0,0,0) : mk_mode(0,0,0,0,1,0,0));
            for (int c = 0; c < 512; c++) begin
                @(negedge clk);
                f_in = c[3:0]; g_in = c[7:4]; h_in = c[8];
                #1;
                fo = ft[f_in]; go = gt[g_in];
                if (t % 2 == 0) begin
                    chk("R2 x_o H of {h,G,F}", x_o, ht[{h_in, go, fo}]);
                    chk("R1 y_o G lookup", y_o, go);
                end else begin
                    chk("R3 x_o takes F", x_o, fo);
                    chk("R3 y_o takes H", y_o, ht[{h_in, go, fo}]);
                end
            end
        end

        // R4 R5 registered paths
        ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
        load(ft, gt, ht, mk_mode(0,0,0,0,0,1,0));
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            ce = 1'b1; f_in = 4'($urandom); g_in = 4'($urandom);
            exp_x = ft[f_in]; exp_y = gt[g_in];
            @(negedge clk); #1;
            chk("R4 xq one edge later", xq, exp_x);
            chk("R4 yq one edge later", yq, exp_y);
            chk("R4 x_o shows flip-flop", x_o, exp_x);
            ce = 1'b0; f_in = ~f_in; g_in = ~g_in;
            @(negedge clk); #1;
            chk("R5 xq holds with ce low", xq, exp_x);
            chk("R4 y_o combinational", y_o, gt[g_in]);
        end
        ce = 1'b1; rst_n = 1'b0;
        f_in = 4'd15;
        @(negedge clk); #1;
        chk("R5 xq sync reset", xq, 0);
        chk("R5 yq sync reset", yq, 0);
        rst_n = 1'b1; ce = 1'b0;

        // R8 R10: 16x2 memory
        ft = 16'($urandom); gt = 16'($urandom);
        load(ft, gt, 8'h00, mk_mode(1,0,0,0,0,0,0));
        mf = ft; mg = gt;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = a[3:0]; g_in = 4'($urandom); wdata = 2'($urandom);
            we = 1'b1; ce = (a % 4 != 3);
            #1;
            chk("R10 old data before edge", x_o, mf[a]);
            if (ce) begin mf[a] = wdata[0]; mg[a] = wdata[1]; end
        end
        @(negedge clk);
        we = 1'b0; ce = 1'b0;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = a[3:0]; g_in = 4'($urandom);
            #1;
            chk("R8 F word readback", x_o, mf[a]);
            chk("R8 G word readback", y_o, mg[a]);
        end

        // R9 R10: 32x1 memory read through H
        ft = 16'($urandom); gt = 16'($urandom);
        load(ft, gt, 8'h00, mk_mode(1,1,0,1,0,0,0));
        m32 = {gt, ft};
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            f_in = a[3:0]; h_in = a[4]; wdata = 2'($urandom);
            we = (a % 5 != 2); ce = 1'b1;
            #1;
            chk("R10 old bit before edge", x_o, m32[a]);
            if (we) m32[a] = wdata[0];
        end
        @(negedge clk);
        we = 1'b0; ce = 1'b0;
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            f_in = a[3:0]; h_in = a[4];
            #1;
            chk("R9 32x1 readback", x_o, m32[a]);
        end

        // R11: two chained tiles form a 4-bit adder
        for (int i = 0; i < 16; i++) begin
            ft[i] = i[0] ^ i[1] ^ i[3];
        end
        load(ft, ft, 8'h00, mk_mode(0,0,1,0,0,0,0));
        for (int c = 0; c < 512; c++) begin
            logic [3:0] a4, b4;
            logic [4:0] s;
            a4 = c[3:0]; b4 = c[7:4];
            @(negedge clk);
            cin  = c[8];
            f_in = {1'b0, 1'($urandom), b4[0], a4[0]};
            g_in = {1'b0, 1'($urandom), b4[1], a4[1]};
            f_hi = {1'b0, 1'($urandom), b4[2], a4[2]};
            g_hi = {1'b0, 1'($urandom), b4[3], a4[3]};
            #1;
            s = a4 + b4 + 5'(cin);
            chk("R11 chained sum", {cout_hi, y_hi, x_hi, y_o, x_o}, s);
            chk("R11 low slice carry", cout, s[2] ^ a4[2] ^ b4[2]);
        end

        // R12: carry disabled, and memory mode overriding carry
        load(ft, ft, 8'h00, mk_mode(0,0,0,0,0,0,0));
        @(negedge clk);
        f_in = 4'b0011; g_in = 4'b0011; cin = 1'b1; #1;
        chk("R12 cout off without carry", cout, 0);
        load(ft, ft, 8'h00, mk_mode(1,0,1,0,0,0,0));
        @(negedge clk);
        f_in = 4'b0011; g_in = 4'b0011; cin = 1'b1; #1;
        chk("R12 cout off in memory mode", cout, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule